// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two parallel buses, called A and B. It carries data in both directions without inverting it. Each direction has its own storage bank and its own three active-low controls: a direction enable, a load control and a drive control. The direction enable gates both the storage bank and the output stage of its path. One path can therefore be frozen and taken off its bus while the other keeps working.

The block has no tri-state pins. Each bus is split into an input vector, an output vector and a drive flag. Wrapping logic builds the real three-state pad from the output vector and the drive flag.

While a path is loading, its stored value follows the source bus. The value seen through the path is the live source value, with no delay. The stored value is updated at each clock edge. When the load control or the direction enable is high, the bank keeps the value it captured at the last edge where both were low. A synchronous reset sets both banks to zero.

Top module: `latched_bus_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both storage banks are set to zero. The first value an enabled path can drive after reset, with its load control high, is zero.
- R2: Each path is WIDTH bits wide (default 8) and passes bit n of the source bus to bit n of the opposite bus, with no inversion.
- R3: When a path's enable and load control are both low, its view follows the source input with no delay. At each clock edge in that state, the bank stores the source input.
- R4: When a path's load control is high, its bank keeps its value. This includes the value captured at the last edge before the control rose. Later changes on the source input do not reach the opposite bus.
- R5: When a path's enable is high, its bank keeps its value and its drive flag is 0, whatever its load and drive controls are set to.
- R6: When a path's drive control is high, its drive flag is 0. The bank still loads if the enable and load control are low.
- R7: A path's drive flag is 1 exactly when its enable and drive control are both low. Its output vector then equals the path's view. While the drive flag is 0, the output vector is all zeros.
- R8: The B-to-A path (`ba_*` controls, `b_in` to `a_out`/`a_drv`) behaves like the A-to-B path (`ab_*` controls, `a_in` to `b_out`/`b_drv`). The two paths do not affect each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the storage banks |
| rst | input | 1 | Synchronous reset, active high, clears both banks |
| a_in | input | WIDTH | Value on bus A as seen by the block |
| b_in | input | WIDTH | Value on bus B as seen by the block |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B load control, active low |
| ab_oe_n | input | 1 | A-to-B drive control, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A load control, active low |
| ba_oe_n | input | 1 | B-to-A drive control, active low |
| b_out | output | WIDTH | Value the block drives onto bus B (zero when not driving) |
| b_drv | output | 1 | Block drives bus B |
| a_out | output | WIDTH | Value the block drives onto bus A (zero when not driving) |
| a_drv | output | 1 | Block drives bus A |

## Verification
The bench steps through all 64 settings of the six control inputs, four times. Each pass uses a different arithmetic data sequence, so a value that is stuck, inverted or taken from the wrong path shows up as a data mismatch. Because every enable, load and drive combination is reached from many different stored states, the bench can tell a live pass-through from a held value. It can also tell a gated enable from a gated drive control. A directed freeze sequence separates the value captured at the last loading edge from later input changes. A contention monitor flags any cycle in which the block drives a bus that the bench is also driving.

// File: rtl/latched_bus_xcvr.sv
module latched_bus_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_en_n,
  input  logic             ab_le_n,
  input  logic             ab_oe_n,
  input  logic             ba_en_n,
  input  logic             ba_le_n,
  input  logic             ba_oe_n,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv
);

  logic [WIDTH-1:0] ab_q, ba_q;
  logic [WIDTH-1:0] ab_view, ba_view;
  logic             ab_load, ba_load;

  assign ab_load = !ab_en_n && !ab_le_n;
  assign ba_load = !ba_en_n && !ba_le_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q <= '0;
      ba_q <= '0;
    end else begin
      if (ab_load) ab_q <= a_in;
      if (ba_load) ba_q <= b_in;
    end
  end

  assign ab_view = ab_load ? a_in : ab_q;
  assign ba_view = ba_load ? b_in : ba_q;

  assign b_drv = !ab_en_n && !ab_oe_n;
  assign a_drv = !ba_en_n && !ba_oe_n;
  assign b_out = b_drv ? ab_view : '0;
  assign a_out = a_drv ? ba_view : '0;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ab_q == '0 && ba_q == '0));

  // R3
  ab_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_en_n && !ab_le_n) |=> ab_q == $past(a_in));

  // R8
  ba_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_en_n && !ba_le_n) |=> ba_q == $past(b_in));

  // R4
  ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ab_en_n || ab_le_n) |=> $stable(ab_q));

  // R4
  ba_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ba_en_n || ba_le_n) |=> $stable(ba_q));

  // R5
  ab_isolate_chk: assert property (@(posedge clk) disable iff (rst)
    ab_en_n |-> (!b_drv && b_out == '0));

  // R5
  ba_isolate_chk: assert property (@(posedge clk) disable iff (rst)
    ba_en_n |-> (!a_drv && a_out == '0));

  // R7
  b_held_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (b_drv && ab_le_n) |-> b_out == ab_q);

  // R7
  a_held_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (a_drv && ba_le_n) |-> a_out == ba_q);

endmodule

// File: tb/latched_bus_xcvr_tb_top.sv
module latched_bus_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
  logic ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic b_drv, a_drv;
  logic ext_a_drv = 1'b1, ext_b_drv = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] m_ab = '0, m_ba = '0;

  always #2 clk = ~clk;

  latched_bus_xcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if ((a_drv && ext_a_drv) || (b_drv && ext_b_drv)) begin
        failures++;
        $display("FAIL R7 contention actual=%0b%0b expected=00",
                 a_drv && ext_a_drv, b_drv && ext_b_drv);
      end
    end
  end

  task automatic check_outputs(input string tag);
    logic [W-1:0] ab_v, ba_v;
    logic bd, ad;
    ab_v = (!ab_en_n && !ab_le_n) ? a_in : m_ab;
    ba_v = (!ba_en_n && !ba_le_n) ? b_in : m_ba;
    bd = !ab_en_n && !ab_oe_n;
    ad = !ba_en_n && !ba_oe_n;
    chk({tag, " R7 b_drv"}, 32'(b_drv), 32'(bd));
    chk({tag, " R7/R2 b_out"}, 32'(b_out), 32'(bd ? ab_v : '0));
    chk({tag, " R8 a_drv"}, 32'(a_drv), 32'(ad));
    chk({tag, " R8/R2 a_out"}, 32'(a_out), 32'(ad ? ba_v : '0));
  endtask

  task automatic step(input logic [5:0] c, input logic [W-1:0] da, input logic [W-1:0] db,
                      input string tag);
    @(negedge clk);
    {ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n} = c;
    a_in = da;
    b_in = db;
    ext_a_drv = ba_en_n | ba_oe_n;
    ext_b_drv = ab_en_n | ab_oe_n;
    #1;
    check_outputs(tag);
    @(posedge clk);
    if (!ab_en_n && !ab_le_n) m_ab = a_in;
    if (!ba_en_n && !ba_le_n) m_ba = b_in;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: stores start from arbitrary data, reset clears them
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(6'b000000, 8'hA5, 8'h3C, "load");
    @(negedge clk);
    rst = 1'b1;
    ab_en_n = 1'b0; ab_le_n = 1'b1; ab_oe_n = 1'b0;
    ba_en_n = 1'b0; ba_le_n = 1'b1; ba_oe_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_ab = '0;
    m_ba = '0;
    #1;
    chk("R1 b_out after reset", 32'(b_out), 32'h0);
    chk("R1 a_out after reset", 32'(a_out), 32'h0);
    chk("R1 b_drv after reset", 32'(b_drv), 32'h1);
    chk("R1 a_drv after reset", 32'(a_drv), 32'h1);

    // R3 R5 R6 R7 R8: exhaustive control sweep with varied data
    for (int pass = 0; pass < 4; pass++) begin
      for (int i = 0; i < 64; i++) begin
        step(6'(i), 8'((i * 37 + pass * 53 + 5) & 8'hFF),
             8'(((i * 91 + pass * 17 + 3) ^ 8'h5A) & 8'hFF), "sweep");
      end
    end

    // R4: freeze A-to-B on load control rising, then change input
    step(6'b000111, 8'h81, 8'h00, "R3 load");
    step(6'b000111, 8'h42, 8'h00, "R3 load");
    step(6'b010111, 8'hFF, 8'h00, "R4 frozen");
    chk("R4 b_out holds last captured", 32'(b_out), 32'h42);
    step(6'b010111, 8'h00, 8'h00, "R4 frozen");
    chk("R4 b_out still holds", 32'(b_out), 32'h42);
    // R5: enable high then low again keeps value even with load low while disabled
    step(6'b100111, 8'h77, 8'h00, "R5 isolated");
    chk("R5 b_drv off while disabled", 32'(b_drv), 32'h0);
    step(6'b010111, 8'h66, 8'h00, "R5 after");
    chk("R5 b_out kept value", 32'(b_out), 32'h42);

    // R8: freeze B-to-A while A-to-B stays transparent
    step(6'b111000, 8'h00, 8'h19, "R8 load");
    step(6'b000010, 8'h2E, 8'hE7, "R8 frozen");
    chk("R8 a_out holds", 32'(a_out), 32'h19);
    chk("R8 b_out transparent", 32'(b_out), 32'h2E);
    // R6: drive off while loading, then drive on with load high shows loaded data
    step(6'b001111, 8'hC3, 8'h00, "R6 load no drive");
    chk("R6 b_drv off", 32'(b_drv), 32'h0);
    step(6'b010111, 8'h00, 8'h00, "R6 shown");
    chk("R6 loaded while undriven", 32'(b_out), 32'hC3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule